// File: doc/BRIEF.md
# Eight-Pin Configurable GPIO Port Controller

This block is a register-mapped general-purpose I/O port. Each pin has its own data bit, and the whole port shares one two-bit mode field. Together they select one of four drive states per pin: pulled low, strong high, weak resistive high or floating. The block produces three drive-control outputs per pin, for a pull-down, a strong pull-up and a weak pull-up. It brings the pad levels through a synchronizer so that software can read them over a small registered bus.

The block also detects pin edges for interrupts. The mode field sets which edge counts: falling in modes 00 and 11, rising in mode 01, and none in the strong-output mode 10. A per-pin enable register gates the detected edges, and the enabled edges are merged into a single interrupt pulse. A global parallel-interface input, when high, blocks that pulse entirely.

Register map: address 0 holds the pin data (write) and returns the synchronized pads (read). Address 1 holds the mode field in bits [1:0]. Address 4 holds the interrupt enables, with bit i belonging to pin i.

Top module: `gpio_port_ctrl`

## Requirements
- R1: When a pin's data bit is 0, its pull-down control is 1 and both pull-up controls are 0, for every mode value.
- R2: With data bit 1 and mode 10, only the strong pull-up control of that pin is 1.
- R3: With data bit 1 and mode 11, only the weak pull-up control of that pin is 1.
- R4: With data bit 1 and mode 00 or 01, all three drive controls of that pin are 0.
- R5: After reset the mode is 00, all data bits are 1 and all interrupt enables are 0. So all drive controls are 0, irq is 0, and reads of address 1 and address 4 return 0.
- R6: A read at address 0 returns the pad levels after a two-stage synchronizer. Read data is registered and valid in the cycle after the read strobe. Address 1 returns the mode field in bits [1:0] with zeros above, and address 4 returns the enables.
- R7: In modes 00 and 11 a falling edge on an enabled pin raises irq for exactly one cycle, and a rising edge does not. In mode 01 only a rising edge does. Edges on several pins in the same cycle produce one pulse.
- R8: In mode 10 no pin edge raises irq, whatever the enables hold.
- R9: An edge on a pin whose enable bit (address 4, bit i for pin i) is 0 does not raise irq.
- R10: While par_mode is 1, no pin edge raises irq.
- R11: For every pin, at most one of the three drive controls is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| par_mode | input | 1 | Parallel-interface mode; blocks all pin interrupts |
| pad_in | input | 8 | Pad levels, asynchronous |
| pd_on | output | 8 | Per-pin pull-down enable |
| spu_on | output | 8 | Per-pin strong pull-up enable |
| wpu_on | output | 8 | Per-pin weak pull-up enable |
| irq | output | 1 | Shared one-cycle interrupt pulse |

## Verification
The hardest situation to reach from the ports is an interrupt edge that coincides with a particular mode and enable state. A pad change takes three register stages to become an interrupt pulse, and the mode in force at detection decides the polarity. The stimulus first parks the pads and lets the synchronizer settle. It then writes the mode and enables, and only then flips pads at a falling clock edge. It counts irq pulses over a window longer than the pipeline, so each pulse is tied to one known edge. Simultaneous edges on two pins check that they merge into a single pulse.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    MODE_FLOAT_F = 2'b00,
    MODE_FLOAT_R = 2'b01,
    MODE_STRONG  = 2'b10,
    MODE_WEAK    = 2'b11
  } port_mode_e;

  localparam logic [2:0] ADR_DATA = 3'd0;
  localparam logic [2:0] ADR_MODE = 3'd1;
  localparam logic [2:0] ADR_IEN  = 3'd4;

  // returns {pull_down, strong_up, weak_up}
  function automatic logic [2:0] drive_sel(input logic [1:0] mode, input logic d);
    logic [2:0] r;
    if (!d)                      r = 3'b100;
    else if (mode == MODE_STRONG) r = 3'b010;
    else if (mode == MODE_WEAK)   r = 3'b001;
    else                          r = 3'b000;
    return r;
  endfunction

  function automatic logic edge_hit(input logic [1:0] mode, input logic prev, input logic cur);
    logic r;
    case (mode)
      MODE_FLOAT_R: r = !prev && cur;
      MODE_STRONG:  r = 1'b0;
      default:      r = prev && !cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic [1:0]       mode,
  input  logic [NPINS-1:0] data,
  output logic [NPINS-1:0] pd_on,
  output logic [NPINS-1:0] spu_on,
  output logic [NPINS-1:0] wpu_on
);
  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic [2:0] sel;
      assign sel       = drive_sel(mode, data[i]);
      assign pd_on[i]  = sel[2];
      assign spu_on[i] = sel[1];
      assign wpu_on[i] = sel[0];
    end
  endgenerate
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [NPINS-1:0] samp,
  input  logic [NPINS-1:0] ien,
  input  logic             par_mode,
  output logic [NPINS-1:0] pin_evt,
  output logic             irq
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= samp;
  end

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_evt
      assign pin_evt[i] = ien[i] && edge_hit(mode, prev_q[i], samp[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (|pin_evt) && !par_mode;
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic              par_mode,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pd_on,
  output logic [NPINS-1:0]  spu_on,
  output logic [NPINS-1:0]  wpu_on,
  output logic              irq
);
  localparam int MODE_W = 2;

  logic [NPINS-1:0]  data_q;
  logic [MODE_W-1:0] cfg_q;
  logic [NPINS-1:0]  ien_q;
  logic [NPINS-1:0]  samp;
  logic [NPINS-1:0]  pin_evt;
  logic              hit_data, hit_mode, hit_ien;

  assign hit_data = (addr == ADDR_W'(ADR_DATA));
  assign hit_mode = (addr == ADDR_W'(ADR_MODE));
  assign hit_ien  = (addr == ADDR_W'(ADR_IEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '1;
      cfg_q  <= MODE_FLOAT_F;
      ien_q  <= '0;
    end else if (wr_en) begin
      if (hit_data) data_q <= wdata;
      if (hit_mode) cfg_q  <= wdata[MODE_W-1:0];
      if (hit_ien)  ien_q  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      if (hit_data)      rdata <= samp;
      else if (hit_mode) rdata <= NPINS'(cfg_q);
      else if (hit_ien)  rdata <= ien_q;
      else               rdata <= '0;
    end
  end

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(samp)
  );

  gpio_drive #(.NPINS(NPINS)) drive_i (
    .mode(cfg_q), .data(data_q), .pd_on(pd_on), .spu_on(spu_on), .wpu_on(wpu_on)
  );

  gpio_edge_irq #(.NPINS(NPINS)) edge_i (
    .clk(clk), .rst_n(rst_n), .mode(cfg_q), .samp(samp), .ien(ien_q),
    .par_mode(par_mode), .pin_evt(pin_evt), .irq(irq)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NPINS-1:0]  rdata,
  input logic              par_mode,
  input logic [1:0]        cfg_q,
  input logic [NPINS-1:0]  ien_q,
  input logic [NPINS-1:0]  pin_evt,
  input logic [NPINS-1:0]  pd_on,
  input logic [NPINS-1:0]  spu_on,
  input logic [NPINS-1:0]  wpu_on,
  input logic              irq
);
  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      // R11
      drive_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pd_on[i], spu_on[i], wpu_on[i]}));
    end
  endgenerate

  // R8
  strong_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_q) == 2'b10) |-> !irq);

  // R10
  par_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(par_mode) |-> !irq);

  // R9
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ien_q) == '0) |-> !irq);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|pin_evt));

  // R6
  mode_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(1)) |=> (rdata == NPINS'($past(cfg_q))));
endmodule

bind gpio_port_ctrl gpio_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .par_mode(par_mode), .cfg_q(cfg_q), .ien_q(ien_q), .pin_evt(pin_evt),
  .pd_on(pd_on), .spu_on(spu_on), .wpu_on(wpu_on), .irq(irq)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, rd_en = 0, par_mode = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, pad_in = 8'hFF;
  logic [7:0] rdata, pd_on, spu_on, wpu_on;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .par_mode(par_mode), .pad_in(pad_in),
    .pd_on(pd_on), .spu_on(spu_on), .wpu_on(wpu_on), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // change pads at a falling edge, count irq high cycles over a window
  task automatic pulse_count(input logic [7:0] p, output int n);
    @(negedge clk); pad_in = p; n = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (irq) n++;
    end
  endtask

  function automatic logic [23:0] exp_drive(input logic [1:0] m, input logic [7:0] d);
    logic [7:0] pd, sp, wp;
    pd = ~d;
    sp = (m == 2'b10) ? d : 8'h00;
    wp = (m == 2'b11) ? d : 8'h00;
    return {pd, sp, wp};
  endfunction

  task automatic t_reset;
    logic [7:0] v;
    check("R5 pd", pd_on, 8'h00);
    check("R5 spu", spu_on, 8'h00);
    check("R5 wpu", wpu_on, 8'h00);
    check("R5 irq", irq, 0);
    rd(3'd1, v); check("R5 mode read", v, 8'h00);
    rd(3'd4, v); check("R5 ien read", v, 8'h00);
  endtask

  task automatic t_drive;
    for (int m = 0; m < 4; m++) begin
      wr(3'd1, 8'(m));
      foreach (pat[j]) begin
        wr(3'd0, pat[j]);
        check(m == 2 ? "R2 R1 drive" : m == 3 ? "R3 R1 drive" : "R4 R1 drive",
              {pd_on, spu_on, wpu_on}, exp_drive(2'(m), pat[j]));
      end
    end
    wr(3'd0, 8'hFF);
  endtask
  logic [7:0] pat [3] = '{8'hA5, 8'h00, 8'hFF};

  task automatic t_read;
    logic [7:0] v;
    pad_in = 8'h3C; settle(4);
    rd(3'd0, v); check("R6 pad read", v, 8'h3C);
    pad_in = 8'hFF; settle(4);
    rd(3'd0, v); check("R6 pad read 2", v, 8'hFF);
    wr(3'd1, 8'hFE); rd(3'd1, v); check("R6 mode read", v, 8'h02);
    wr(3'd4, 8'h5A); rd(3'd4, v); check("R6 ien read", v, 8'h5A);
  endtask

  task automatic t_edges;
    int n;
    wr(3'd4, 8'hFF);
    wr(3'd1, 8'h00); settle(4);
    pulse_count(8'hFE, n); check("R7 mode00 fall", n, 1);
    pulse_count(8'hFF, n); check("R7 mode00 rise", n, 0);
    wr(3'd1, 8'h01); settle(4);
    pulse_count(8'hFE, n); check("R7 mode01 fall", n, 0);
    pulse_count(8'hFF, n); check("R7 mode01 rise", n, 1);
    wr(3'd1, 8'h03); settle(4);
    pulse_count(8'hF6, n); check("R7 mode11 two pins fall", n, 1);
    pulse_count(8'hFF, n); check("R7 mode11 rise", n, 0);
  endtask

  task automatic t_strong;
    int n;
    wr(3'd1, 8'h02); settle(4);
    pulse_count(8'h00, n); check("R8 strong fall", n, 0);
    pulse_count(8'hFF, n); check("R8 strong rise", n, 0);
  endtask

  task automatic t_enable;
    int n;
    wr(3'd1, 8'h00); wr(3'd4, 8'hFE); settle(4);
    pulse_count(8'hFE, n); check("R9 disabled pin0", n, 0);
    pulse_count(8'hFF, n);
    pulse_count(8'hFD, n); check("R9 enabled pin1", n, 1);
    pulse_count(8'hFF, n);
  endtask

  task automatic t_par;
    int n;
    wr(3'd4, 8'hFF); par_mode = 1; settle(4);
    pulse_count(8'h00, n); check("R10 par blocks", n, 0);
    pulse_count(8'hFF, n);
    par_mode = 0; settle(2);
    pulse_count(8'h7F, n); check("R10 par released", n, 1);
    pulse_count(8'hFF, n);
  endtask

  initial begin
    settle(3); rst_n = 1; settle(1);
    t_reset();
    t_drive();
    t_read();
    t_edges();
    t_strong();
    t_enable();
    t_par();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule